// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog for a system that runs from a slow timebase. A counter counts up on a slow tick, which reaches the block as a one-cycle enable. An optional prescaler can divide that tick first. If the counter rolls over from all ones to zero while the timer runs, the block pulses a reset request for one clock. Software keeps the system alive by changing the value in the trigger register. A new trigger value copies the reload value into the counter, which pushes the next expiry back. A timeout of S seconds with a 32768 Hz tick is set by loading 2^32 − S·32768.

Turning the timer on or off takes a two-word key. Both words go, one after the other, into the key register. A wrong second word cancels the pending first word, so one stray write cannot start or stop the watchdog.

Every register write is posted. The new value sits in a holding slot, and its pending flag is set until a fixed number of slow ticks has gone by. At that point the value takes effect in the timer domain and the flag drops. Software polls the pending flags before it relies on a write.

Top module: `guard_timer`

## Requirements
- R1: After a synchronous active-low reset, the counter, reload, control and trigger registers read zero. No write is pending, the timer is stopped and `wdt_rst` is low.
- R2: Offset 0x00 reads the revision, with the major number in bits 7:4 and the minor number in bits 3:0. The default is 0x31.
- R3: A write sets a pending bit in the status register at offset 0x34, starting the cycle after the write. The bits are: bit 0 control (0x24), bit 1 counter (0x28), bit 2 reload (0x2C), bit 3 trigger (0x30), bit 4 key (0x48). The written value takes effect, and the bit clears, on the POST_TICKS-th `tick_en` cycle after the write.
- R4: The timer starts when 0x0000BBBB takes effect in the key register and 0x00004444 is the next value to take effect there.
- R5: The timer stops when 0x0000AAAA takes effect in the key register and 0x00005555 is the next value to take effect there. A stopped timer holds its count.
- R6: If the word after a first key word is not the matching second word, the first word is discarded and the run state does not change. Values that are not a first key word are ignored.
- R7: While running with the prescaler off, the counter increases by one on each `tick_en` cycle.
- R8: Control bit 5 enables the prescaler and bits 4:2 select P. While enabled, the counter increases once every 2^P ticks.
- R9: A trigger value that differs from the current trigger contents copies the reload register into the counter when it takes effect. An equal value has no effect on the counter.
- R10: A value that takes effect in the counter register replaces the count.
- R11: When the count is 0xFFFFFFFF and it steps, the count becomes zero and `wdt_rst` is high for exactly the next cycle.
- R12: If a trigger reload, a counter write and a count step fall on the same edge, the reload wins, then the counter write, then the step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle pulse per slow timebase tick |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Register byte offset |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr` (combinational) |
| wdt_rst | output | 1 | One-cycle reset request on expiry |

## Verification
The count path runs under three tick patterns: an enable on every clock, an enable on every third clock, and no tick at all. With no tick, the posted writes stall, which lets a counter write and a trigger reload take effect on the same edge and shows which one wins. The key path gets correct pairs, a wrong second word for both start and stop, and repeated trigger values. These separate a real key match from a match on one word alone, and a reload on change from a reload on every write. A behavioural model follows the counter, pending bits and reset request on every clock, so an error of one tick in the posting delay or the prescaler is reported.

// File: rtl/gt_pkg.sv
// Package for the keyed watchdog: slot indices, register offsets, key words
// and the key-sequence state type. Assumes an address bus of at least 7 bits.
package gt_pkg;
    localparam int NSLOT    = 5;
    // Slot index equals the bit position in the pending-status register.
    localparam int SL_CTRL  = 0;
    localparam int SL_CNT   = 1;
    localparam int SL_LOAD  = 2;
    localparam int SL_TRIG  = 3;
    localparam int SL_KEY   = 4;

    localparam logic [7:0] OFS_REV  = 8'h00;
    localparam logic [7:0] OFS_CTRL = 8'h24;
    localparam logic [7:0] OFS_CNT  = 8'h28;
    localparam logic [7:0] OFS_LOAD = 8'h2C;
    localparam logic [7:0] OFS_TRIG = 8'h30;
    localparam logic [7:0] OFS_PEND = 8'h34;
    localparam logic [7:0] OFS_KEY  = 8'h48;

    localparam logic [15:0] KEY_ON1  = 16'hBBBB;
    localparam logic [15:0] KEY_ON2  = 16'h4444;
    localparam logic [15:0] KEY_OFF1 = 16'hAAAA;
    localparam logic [15:0] KEY_OFF2 = 16'h5555;

    typedef enum logic [1:0] {
        KS_IDLE    = 2'd0,
        KS_ARM_ON  = 2'd1,
        KS_ARM_OFF = 2'd2
    } key_state_t;

    // Byte offset of each posted slot.
    function automatic logic [7:0] slot_ofs(input int idx);
        case (idx)
            SL_CTRL: return OFS_CTRL;
            SL_CNT:  return OFS_CNT;
            SL_LOAD: return OFS_LOAD;
            SL_TRIG: return OFS_TRIG;
            default: return OFS_KEY;
        endcase
    endfunction
endpackage

// File: rtl/gt_post.sv
// One posted-write slot. It holds the last written value and counts slow
// ticks down from POST_TICKS. The commit strobe fires on the tick edge where
// the count reaches zero. A new write restarts the count and replaces the value.
// Assumes POST_TICKS >= 1.
module gt_post #(
    parameter int DW         = 32,
    parameter int POST_TICKS = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_hit,
    input  logic [DW-1:0] wdata,
    input  logic          tick,
    output logic [DW-1:0] hold,
    output logic          pending,
    output logic          commit
);
    localparam int CW = $clog2(POST_TICKS + 1);
    localparam logic [CW-1:0] START = CW'(POST_TICKS);
    localparam logic [CW-1:0] LAST  = CW'(1);

    logic [CW-1:0] left_q;
    logic [DW-1:0] hold_q;

    // Capture a write and count down the ticks until it takes effect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
            hold_q <= '0;
        end else if (wr_hit) begin
            left_q <= START;
            hold_q <= wdata;
        end else if (tick && left_q != '0) begin
            left_q <= left_q - LAST;
        end
    end

    assign hold    = hold_q;
    assign pending = (left_q != '0);
    assign commit  = tick && !wr_hit && (left_q == LAST);

    a_r3_pending_set: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> pending);
    a_r3_commit_clears: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !pending);
    a_r3_value_held: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(hold));
endmodule

// File: rtl/gt_keylock.sv
// Key-sequence lock for the run state. It watches values as they take
// effect in the key slot. A first word arms the lock, and only the matching
// second word on the next commit changes the run state. Any other second word
// disarms the lock. Assumes DW >= 16; the upper bits must be zero to match.
module gt_keylock
    import gt_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          commit,
    input  logic [DW-1:0] key,
    output logic          running
);
    localparam logic [DW-1:0] W_ON1  = DW'(KEY_ON1);
    localparam logic [DW-1:0] W_ON2  = DW'(KEY_ON2);
    localparam logic [DW-1:0] W_OFF1 = DW'(KEY_OFF1);
    localparam logic [DW-1:0] W_OFF2 = DW'(KEY_OFF2);

    key_state_t state_q, state_d;
    logic       run_q, run_d;

    // Next-state decode for each committed key word.
    always_comb begin
        state_d = state_q;
        run_d   = run_q;
        if (commit) begin
            case (state_q)
                KS_ARM_ON: begin
                    if (key == W_ON2) run_d = 1'b1;
                    state_d = KS_IDLE;
                end
                KS_ARM_OFF: begin
                    if (key == W_OFF2) run_d = 1'b0;
                    state_d = KS_IDLE;
                end
                default: begin
                    if (key == W_ON1)       state_d = KS_ARM_ON;
                    else if (key == W_OFF1) state_d = KS_ARM_OFF;
                    else                    state_d = KS_IDLE;
                end
            endcase
        end
    end

    // State and run-flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= KS_IDLE;
            run_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
        end
    end

    assign running = run_q;

    a_r4_start_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> $past(commit && key == W_ON2 && state_q == KS_ARM_ON));
    a_r5_stop_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running) |-> $past(commit && key == W_OFF2 && state_q == KS_ARM_OFF));
    a_r6_wrong_second: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && state_q != KS_IDLE && key != W_ON2 && key != W_OFF2)
        |=> $stable(running) && state_q == KS_IDLE);
endmodule

// File: rtl/gt_count.sv
// Up-counter with prescaler and expiry detection. Priority per edge:
// trigger reload, then a direct counter write, then a step. The prescaler
// counts slow ticks only while running and is cleared while stopped.
// Expiry registers a one-cycle pulse on the edge after an all-ones step.
module gt_count #(
    parameter int DW     = 32,
    parameter int PSEL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              running,
    input  logic              pre_en,
    input  logic [PSEL_W-1:0] pre_sel,
    input  logic              reload,
    input  logic [DW-1:0]     load_val,
    input  logic              cnt_wr,
    input  logic [DW-1:0]     cnt_val,
    output logic [DW-1:0]     count,
    output logic              expire
);
    localparam int PCW = (1 << PSEL_W) - 1;
    localparam logic [DW-1:0] TOP = '1;

    logic [PCW-1:0] pre_q;
    logic [PCW-1:0] pre_lim;
    logic           pre_hit;
    logic           step;
    logic [DW-1:0]  cnt_q;
    logic           exp_q;

    // Terminal prescaler value: 2^P - 1.
    always_comb begin
        pre_lim = ~({PCW{1'b1}} << pre_sel);
        pre_hit = (pre_q >= pre_lim);
        step    = running && tick && (!pre_en || pre_hit);
    end

    // Prescaler phase counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !running) begin
            pre_q <= '0;
        end else if (tick) begin
            if (!pre_en || pre_hit) pre_q <= '0;
            else                    pre_q <= pre_q + 1'b1;
        end
    end

    // Main counter with reload/write/step priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (reload) begin
            cnt_q <= load_val;
        end else if (cnt_wr) begin
            cnt_q <= cnt_val;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Registered expiry pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) exp_q <= 1'b0;
        else        exp_q <= step && !reload && !cnt_wr && (cnt_q == TOP);
    end

    assign count  = cnt_q;
    assign expire = exp_q;

    a_r11_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !reload && !cnt_wr && count == TOP) |=> (count == '0) && expire);
    a_r11_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !expire);
    a_r5_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !reload && !cnt_wr) |=> $stable(count));
    a_r8_prescale_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_en && !pre_hit && !reload && !cnt_wr) |=> $stable(count));
    a_r12_reload_first: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> count == $past(load_val));
    a_r10_write_second: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr && !reload) |=> count == $past(cnt_val));
endmodule

// File: rtl/guard_timer.sv
// Keyed watchdog timer, top level. It decodes register writes into five
// posted slots, keeps the committed control, reload, trigger and key values,
// and drives the counter and key lock. It also serves a combinational read port.
// Assumes AW >= 7, DW >= 16, and that tick_en is synchronous to clk.
module guard_timer
    import gt_pkg::*;
#(
    parameter int DW         = 32,
    parameter int AW         = 8,
    parameter int POST_TICKS = 2,
    parameter int REV_MAJOR  = 3,
    parameter int REV_MINOR  = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          wdt_rst
);
    localparam int PSEL_W = 3;
    localparam int CTRL_W = PSEL_W + 3;
    localparam int PRE_EN_BIT = CTRL_W - 1;
    localparam logic [DW-1:0] REV_WORD = DW'({4'(REV_MAJOR), 4'(REV_MINOR)});

    logic [NSLOT-1:0] hit;
    logic [NSLOT-1:0] pend;
    logic [NSLOT-1:0] cmt;
    logic [DW-1:0]    hold [NSLOT];

    logic [CTRL_W-1:0] ctrl_q;
    logic [DW-1:0]     load_q;
    logic [DW-1:0]     trig_q;
    logic [DW-1:0]     key_q;
    logic              running;
    logic              reload;
    logic [DW-1:0]     count;

    // One posted slot per writable register.
    for (genvar gi = 0; gi < NSLOT; gi++) begin : g_slot
        assign hit[gi] = bus_wr && (bus_addr == AW'(slot_ofs(gi)));
        gt_post #(.DW(DW), .POST_TICKS(POST_TICKS)) u_post (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_hit (hit[gi]),
            .wdata  (bus_wdata),
            .tick   (tick_en),
            .hold   (hold[gi]),
            .pending(pend[gi]),
            .commit (cmt[gi])
        );
    end

    assign reload = cmt[SL_TRIG] && (hold[SL_TRIG] != trig_q);

    // Committed copies of control, reload, trigger and key registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            load_q <= '0;
            trig_q <= '0;
            key_q  <= '0;
        end else begin
            if (cmt[SL_CTRL]) ctrl_q <= hold[SL_CTRL][CTRL_W-1:0];
            if (cmt[SL_LOAD]) load_q <= hold[SL_LOAD];
            if (cmt[SL_TRIG]) trig_q <= hold[SL_TRIG];
            if (cmt[SL_KEY])  key_q  <= hold[SL_KEY];
        end
    end

    gt_keylock #(.DW(DW)) u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (cmt[SL_KEY]),
        .key    (hold[SL_KEY]),
        .running(running)
    );

    gt_count #(.DW(DW), .PSEL_W(PSEL_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_en),
        .running (running),
        .pre_en  (ctrl_q[PRE_EN_BIT]),
        .pre_sel (ctrl_q[PRE_EN_BIT-1:2]),
        .reload  (reload),
        .load_val(load_q),
        .cnt_wr  (cmt[SL_CNT]),
        .cnt_val (hold[SL_CNT]),
        .count   (count),
        .expire  (wdt_rst)
    );

    // Read multiplexer over committed state.
    always_comb begin
        case (bus_addr)
            AW'(OFS_REV):  bus_rdata = REV_WORD;
            AW'(OFS_CTRL): bus_rdata = DW'(ctrl_q);
            AW'(OFS_CNT):  bus_rdata = count;
            AW'(OFS_LOAD): bus_rdata = load_q;
            AW'(OFS_TRIG): bus_rdata = trig_q;
            AW'(OFS_PEND): bus_rdata = DW'(pend);
            AW'(OFS_KEY):  bus_rdata = key_q;
            default:       bus_rdata = '0;
        endcase
    end

    a_r9_same_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt[SL_TRIG] && hold[SL_TRIG] == trig_q && !cmt[SL_CNT] && !running)
        |=> $stable(count));
    a_r9_new_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt[SL_TRIG] && hold[SL_TRIG] != trig_q) |=> count == $past(load_q));
    a_r3_pending_onehot_write: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));
endmodule

// File: tb/test_guard_timer.sv
module test_guard_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdt_rst;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    int tick_per = 1;
    int tick_ph = 0;
    int pulses = 0;
    bit prev_rst = 0;

    always #10 clk = ~clk;

    guard_timer i_guard_timer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wdt_rst(wdt_rst)
    );

    // ---------------- reference model ----------------
    localparam int PT = 2;
    logic [31:0] m_cnt, m_load, m_trig, m_key;
    logic [5:0]  m_ctrl;
    logic [31:0] m_hold [5];
    int          m_left [5];
    bit          m_cm [5];
    bit          m_run, m_rst;
    int          m_arm;   // 0 none, 1 start armed, 2 stop armed
    int          m_pre;

    function automatic int slot_of(logic [7:0] a);
        case (a)
            8'h24: return 0;
            8'h28: return 1;
            8'h2C: return 2;
            8'h30: return 3;
            8'h48: return 4;
            default: return -1;
        endcase
    endfunction

    function automatic logic [31:0] mread(logic [7:0] a);
        logic [31:0] p;
        p = '0;
        for (int i = 0; i < 5; i++) p[i] = (m_left[i] != 0);
        case (a)
            8'h00: return 32'h31;
            8'h24: return {26'd0, m_ctrl};
            8'h28: return m_cnt;
            8'h2C: return m_load;
            8'h30: return m_trig;
            8'h34: return p;
            8'h48: return m_key;
            default: return '0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_load = 0; m_trig = 0; m_key = 0; m_ctrl = 0;
            m_run = 0; m_rst = 0; m_arm = 0; m_pre = 0;
            for (int i = 0; i < 5; i++) begin m_hold[i] = 0; m_left[i] = 0; end
        end else begin
            bit stepped, rr, nrun;
            int lim;
            for (int i = 0; i < 5; i++) begin
                m_cm[i] = 0;
                if (bus_wr && slot_of(bus_addr) == i) begin
                    m_hold[i] = bus_wdata; m_left[i] = PT;
                end else if (tick_en && m_left[i] > 0) begin
                    m_left[i]--; m_cm[i] = (m_left[i] == 0);
                end
            end
            rr = 0; stepped = 0; nrun = m_run;
            lim = (1 << m_ctrl[4:2]) - 1;
            if (!m_run) m_pre = 0;
            else if (tick_en) begin
                if (!m_ctrl[5]) begin stepped = 1; m_pre = 0; end
                else if (m_pre >= lim) begin stepped = 1; m_pre = 0; end
                else m_pre++;
            end
            if (m_cm[3] && m_hold[3] != m_trig) m_cnt = m_load;
            else if (m_cm[1]) m_cnt = m_hold[1];
            else if (stepped) begin
                if (m_cnt == 32'hFFFF_FFFF) rr = 1;
                m_cnt = m_cnt + 1;
            end
            if (m_cm[3]) m_trig = m_hold[3];
            if (m_cm[2]) m_load = m_hold[2];
            if (m_cm[0]) m_ctrl = m_hold[0][5:0];
            if (m_cm[4]) begin
                m_key = m_hold[4];
                if (m_arm == 1) begin if (m_hold[4] == 32'h4444) nrun = 1; m_arm = 0; end
                else if (m_arm == 2) begin if (m_hold[4] == 32'h5555) nrun = 0; m_arm = 0; end
                else if (m_hold[4] == 32'hBBBB) m_arm = 1;
                else if (m_hold[4] == 32'hAAAA) m_arm = 2;
            end
            m_run = nrun;
            m_rst = rr;
        end
    end

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison with the model, away from the clock edge.
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            check(wdt_rst == m_rst, "R11 model reset request", 32'(wdt_rst), 32'(m_rst));
            check(bus_rdata == mread(bus_addr), "R3 model readback", bus_rdata, mread(bus_addr));
            if (wdt_rst) pulses++;
            if (wdt_rst && prev_rst)
                check(0, "R11 pulse width", 32'd2, 32'd1);
            prev_rst = wdt_rst;
        end
    end

    // Slow-tick generator; a period of 0 stops ticking.
    always @(negedge clk) begin
        if (tick_per == 0) tick_en <= 1'b0;
        else begin
            tick_ph = (tick_ph + 1) % tick_per;
            tick_en <= (tick_ph == 0);
        end
    end

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #2;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] v, c1, c2;
        idle(3);
        rst_n = 1;
        // R1 reset state
        rd(8'h28, v); check(v == 0, "R1 counter after reset", v, 0);
        rd(8'h34, v); check(v == 0, "R1 nothing pending", v, 0);
        rd(8'h2C, v); check(v == 0, "R1 reload zero", v, 0);
        check(wdt_rst == 0, "R1 reset request low", 32'(wdt_rst), 0);
        // R2 revision
        rd(8'h00, v); check(v == 32'h31, "R2 revision", v, 32'h31);
        // R5 stopped timer holds
        idle(10); rd(8'h28, v); check(v == 0, "R5 stopped holds", v, 0);
        // R3 posting of the reload register
        wr(8'h2C, 32'hFFFF_FF00);
        rd(8'h34, v); check(v == 32'h4, "R3 reload pending bit 2", v, 32'h4);
        idle(3);
        rd(8'h34, v); check(v == 0, "R3 pending clears", v, 0);
        rd(8'h2C, v); check(v == 32'hFFFF_FF00, "R3 reload took effect", v, 32'hFFFF_FF00);
        // R6 bad second start word
        wr(8'h48, 32'hBBBB); idle(3);
        wr(8'h48, 32'h1234); idle(3);
        wr(8'h48, 32'h4444); idle(10);
        rd(8'h28, v); check(v == 0, "R6 bad start key ignored", v, 0);
        // R4 start, R7 counting
        wr(8'h48, 32'hBBBB); idle(3);
        wr(8'h48, 32'h4444); idle(3);
        rd(8'h28, c1); idle(5); rd(8'h28, c2);
        check(c2 - c1 == 5, "R4 R7 counts one per tick", c2 - c1, 5);
        // R9 equal trigger does nothing, changed trigger reloads
        wr(8'h30, 32'h0); idle(3);
        rd(8'h28, v); check(v < 32'h100, "R9 equal trigger no reload", v, 32'h40);
        wr(8'h30, 32'h7); idle(3);
        rd(8'h28, v); check(v >= 32'hFFFF_FF00, "R9 changed trigger reloads", v, 32'hFFFF_FF01);
        // R11 expiry
        idle(300);
        check(pulses == 1, "R11 one expiry pulse", pulses, 1);
        rd(8'h28, v); check(v < 32'h200, "R11 counter wrapped", v, 32'h30);
        // R6 bad stop word keeps running
        wr(8'h48, 32'hAAAA); idle(3);
        wr(8'h48, 32'h5556); idle(3);
        rd(8'h28, c1); idle(4); rd(8'h28, c2);
        check(c2 != c1, "R6 bad stop key keeps running", c2, c1 + 4);
        // R5 stop
        wr(8'h48, 32'hAAAA); idle(3);
        wr(8'h48, 32'h5555); idle(3);
        rd(8'h28, c1); idle(10); rd(8'h28, c2);
        check(c2 == c1, "R5 stop holds count", c2, c1);
        // R12 reload beats counter write on one edge (ticks paused)
        tick_per = 0;
        wr(8'h28, 32'h100);
        wr(8'h30, 32'h9);
        rd(8'h34, v); check(v == 32'hA, "R3 counter and trigger pending", v, 32'hA);
        tick_per = 1; idle(4);
        rd(8'h28, v); check(v == 32'hFFFF_FF00, "R12 reload wins", v, 32'hFFFF_FF00);
        // R10 direct counter write
        wr(8'h28, 32'h0); idle(3);
        rd(8'h28, v); check(v == 0, "R10 counter write", v, 0);
        // R8 prescaler, P=2
        wr(8'h24, 32'h28); idle(3);
        rd(8'h24, v); check(v == 32'h28, "R8 control readback", v, 32'h28);
        wr(8'h48, 32'hBBBB); idle(3);
        wr(8'h48, 32'h4444); idle(3);
        rd(8'h28, c1); idle(40); rd(8'h28, c2);
        check((c2 - c1) >= 9 && (c2 - c1) <= 11, "R8 divide by four", c2 - c1, 10);
        // R7 with slower tick, prescaler off
        wr(8'h24, 32'h0); idle(3);
        tick_per = 3; idle(6);
        rd(8'h28, c1); idle(30); rd(8'h28, c2);
        check(c2 - c1 == 10, "R7 slow tick rate", c2 - c1, 10);
        idle(5);
        finish_run();
    end
endmodule